// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Port with Watermark Interrupts

This block sits between a 32-bit register bus and a serial shift engine. Software writes bytes into a transmit queue and reads bytes out of a receive queue through two data registers. The top bit of each data register's read value reports the queue condition: "transmit queue full" for the transmit register and "receive queue empty, data invalid" for the receive register. On the engine side, the transmit queue is drained through a valid/ready output stream and the receive queue is filled through a valid/ready input stream.

Two programmable watermarks turn queue occupancy into level-sensitive pending flags. The transmit flag is raised while the transmit occupancy is below its watermark. The receive flag is raised while the receive occupancy is above its watermark. An enable register masks these flags onto a single interrupt line. Software uses the flags either by polling or through the interrupt. For a burst of n bytes, it sets the receive watermark to n-1 and waits for the receive flag.

Back-pressure rules: on the transmit stream, a byte moves on a cycle where both `tx_valid` and `tx_ready` are high. `tx_valid` stays high while the queue holds data, and `tx_data` stays stable until the byte is taken. On the receive stream, a byte is stored on a cycle where both `rx_valid` and `rx_ready` are high. `rx_ready` is low whenever the receive queue is full, and any byte offered while it is low is not stored.

Top module: `spi_fifo_port`

## Requirements
- R1: After reset, both queues are empty, the transmit watermark reads 1, the receive watermark reads 0, the enable register reads 0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: A write to the transmit data register (word address 0) enqueues bits 7:0 of the write data and ignores bits 31:8. Bytes leave on the transmit stream in write order, one per cycle with `tx_valid` and `tx_ready` both high.
- R3: Reading the transmit data register returns bit 31 set exactly when the transmit queue holds DEPTH entries. A write to it while the queue is full is discarded and never appears on the stream.
- R4: A byte offered on the receive stream is stored when `rx_valid` and `rx_ready` are both high. `rx_ready` is low exactly when the receive queue holds DEPTH entries. Stored bytes keep their arrival order.
- R5: Reading the receive data register (word address 1) returns the oldest byte in bits 7:0 with bit 31 clear and removes that byte. When the queue is empty, bit 31 reads set and the read changes no state.
- R6: Pending bit 0 (transmit watermark) is 1 exactly when the transmit occupancy is strictly less than the transmit watermark (word address 2).
- R7: Pending bit 1 (receive watermark) is 1 exactly when the receive occupancy is strictly greater than the receive watermark (word address 3).
- R8: `irq` is high exactly when some pending bit and the enable bit at the same position (word address 4, bit 0 transmit, bit 1 receive) are both 1. The enable register keeps only bits 1:0.
- R9: The pending register (word address 5) is read-only. Writes to it do not change its value.
- R10: Watermark registers keep the low $clog2(DEPTH+1) bits of the write data. Reads of unmapped word addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe; read data is valid in the same cycle |
| reg_rdata | output | 32 | Register read data, zero when no read is active |
| tx_valid | output | 1 | Transmit stream holds a byte |
| tx_ready | input | 1 | Engine accepts the transmit byte |
| tx_data | output | WIDTH (8) | Transmit byte at the queue head |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive queue can store a byte |
| rx_data | input | WIDTH (8) | Received byte |
| irq | output | 1 | Masked watermark interrupt |

## Verification
A corrupted occupancy counter appears in the same cycle as a wrong pending bit for some watermark value, and as a wrong full flag, `tx_valid` or `rx_ready`. The bench therefore sweeps every watermark against every occupancy from empty to full. A pointer fault that leaves the counter intact shows up only as a byte arriving out of order or repeated. Each byte is tagged with its position, so the first such byte is caught on the read or stream handshake that returns it. Discarded writes and empty reads are judged by the bytes and flags that follow them, before any further stimulus.

// File: rtl/sfp_pkg.sv
`timescale 1ns/1ps
package sfp_pkg;
  localparam int ADDR_W   = 3;
  localparam int BUS_W    = 32;
  localparam int FLAG_BIT = BUS_W - 1;
  localparam int N_WM     = 2;
  localparam int WM_TX    = 0;
  localparam int WM_RX    = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_TXDATA  = 3'd0,
    RA_RXDATA  = 3'd1,
    RA_TXMARK  = 3'd2,
    RA_RXMARK  = 3'd3,
    RA_IRQEN   = 3'd4,
    RA_IRQPEND = 3'd5,
    RA_RSV6    = 3'd6,
    RA_RSV7    = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/sfp_fifo.sv
`timescale 1ns/1ps
module sfp_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfp_wm_irq.sv
`timescale 1ns/1ps
module sfp_wm_irq
  import sfp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_mark,
  input  logic [CNT_W-1:0] rx_mark,
  input  logic [N_WM-1:0]  enable,
  output logic [N_WM-1:0]  pending,
  output logic             irq
);
  logic [N_WM-1:0] term;

  assign pending[WM_TX] = (tx_count < tx_mark);
  assign pending[WM_RX] = (rx_count > rx_mark);

  for (genvar g = 0; g < N_WM; g++) begin : g_term
    assign term[g] = pending[g] & enable[g];
  end

  assign irq = |term;
endmodule

// File: rtl/spi_fifo_port.sv
`timescale 1ns/1ps
module spi_fifo_port
  import sfp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WIDTH-1:0]  tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WIDTH-1:0]  rx_data,
  output logic              irq
);
  reg_addr_e        addr;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic [CNT_W-1:0] tx_mark_q, rx_mark_q;
  logic [N_WM-1:0]  irq_en_q, pending;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [WIDTH-1:0] rx_head;
  logic             tx_push, rx_pop;
  logic             unused_wdata;

  assign addr         = reg_addr_e'(reg_addr);
  assign unused_wdata = ^reg_wdata[31:WIDTH];

  assign tx_push = reg_wr && (addr == RA_TXDATA);
  assign rx_pop  = reg_rd && (addr == RA_RXDATA);

  sfp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(reg_wdata[WIDTH-1:0]),
    .pop(tx_valid && tx_ready), .head(tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  sfp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .push_data(rx_data),
    .pop(rx_pop), .head(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_mark_q <= CNT_W'(1);
      rx_mark_q <= '0;
      irq_en_q  <= '0;
    end else if (reg_wr) begin
      case (addr)
        RA_TXMARK: tx_mark_q <= reg_wdata[CNT_W-1:0];
        RA_RXMARK: rx_mark_q <= reg_wdata[CNT_W-1:0];
        RA_IRQEN:  irq_en_q  <= reg_wdata[N_WM-1:0];
        default:   ;
      endcase
    end
  end

  sfp_wm_irq #(.CNT_W(CNT_W)) wm_i (
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_mark(tx_mark_q), .rx_mark(rx_mark_q),
    .enable(irq_en_q), .pending(pending), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (addr)
        RA_TXDATA:  reg_rdata[FLAG_BIT] = tx_full;
        RA_RXDATA: begin
          reg_rdata[FLAG_BIT] = rx_empty;
          if (!rx_empty) reg_rdata[WIDTH-1:0] = rx_head;
        end
        RA_TXMARK:  reg_rdata[CNT_W-1:0] = tx_mark_q;
        RA_RXMARK:  reg_rdata[CNT_W-1:0] = rx_mark_q;
        RA_IRQEN:   reg_rdata[N_WM-1:0]  = irq_en_q;
        RA_IRQPEND: reg_rdata[N_WM-1:0]  = pending;
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfp_checker.sv
`timescale 1ns/1ps
module sfp_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             irq,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_mark,
  input logic [CNT_W-1:0] rx_mark,
  input logic [1:0]       irq_en
);
  // R2: stream offers data exactly while the transmit queue is occupied
  p_tx_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid == (tx_cnt != '0));

  // R3: transmit occupancy never passes the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH));

  // R3: a write into a full queue without a concurrent drain leaves it full
  p_full_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CNT_W'(DEPTH) && reg_wr && reg_addr == 3'd0 && !tx_ready)
      |=> tx_cnt == CNT_W'(DEPTH));

  // R4: back-pressure tracks receive fullness
  p_rx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready == (rx_cnt != CNT_W'(DEPTH)));

  // R5: reading an empty receive queue without a push keeps it empty
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && reg_rd && reg_addr == 3'd1 && !rx_valid)
      |=> rx_cnt == '0);

  // R8: interrupt matches an enabled watermark condition
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((irq_en[0] && (tx_cnt < tx_mark)) || (irq_en[1] && (rx_cnt > rx_mark))));
endmodule

bind spi_fifo_port sfp_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .tx_cnt(tx_count), .rx_cnt(rx_count),
  .tx_mark(tx_mark_q), .rx_mark(rx_mark_q), .irq_en(irq_en_q)
);

// File: tb/spi_fifo_port_tb.sv
`timescale 1ns/1ps
module spi_fifo_port_tb_top;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [2:0] A_TX = 3'd0, A_RX = 3'd1, A_TXM = 3'd2, A_RXM = 3'd3,
                         A_EN = 3'd4, A_PEND = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_valid, rx_ready, irq;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [WIDTH-1:0] tx_data;
  logic [WIDTH-1:0] rx_data = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [WIDTH-1:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(input logic [WIDTH-1:0] exp);
    @(negedge clk);
    #1;
    check("R2 tx_valid", 32'(tx_valid), 32'd1);
    check("R2 tx order", 32'(tx_data), 32'(exp));
    tx_ready = 1'b1;
    @(posedge clk); #1;
    tx_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_read(A_TXM, d);  check("R1 tx mark", d, 32'd1);
    reg_read(A_RXM, d);  check("R1 rx mark", d, 32'd0);
    reg_read(A_EN, d);   check("R1 enables", d, 32'd0);
    reg_read(A_TX, d);   check("R1 tx flag", d, 32'd0);
    reg_read(A_RX, d);   check("R1 rx empty", d, 32'h8000_0000);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 tx_valid", 32'(tx_valid), 32'd0);
    check("R1 rx_ready", 32'(rx_ready), 32'd1);

    // R10 register width and unmapped space
    reg_write(A_TXM, 32'hFFFF_FFF5);
    reg_read(A_TXM, d);  check("R10 mark mask", d, 32'hFFFF_FFF5 & ((32'd1 << CNT_W) - 1));
    reg_read(3'd6, d);   check("R10 addr6", d, 32'd0);
    reg_read(3'd7, d);   check("R10 addr7", d, 32'd0);
    reg_write(A_EN, 32'hFFFF_FFFF);
    reg_read(A_EN, d);   check("R8 enable mask", d, 32'd3);
    reg_write(A_EN, 32'd0);

    // R6 / R3 sweep: every occupancy against every watermark
    for (int occ = 0; occ <= DEPTH; occ++) begin
      for (int m = 0; m <= DEPTH; m++) begin
        reg_write(A_TXM, 32'(m));
        reg_read(A_PEND, d);
        check("R6 tx pend", 32'(d[0]), 32'(occ < m));
      end
      reg_read(A_TX, d);
      check("R3 full flag", d, (occ == DEPTH) ? 32'h8000_0000 : 32'd0);
      if (occ < DEPTH) reg_write(A_TX, 32'hFFFF_FF00 | 32'(8'hA0 + occ));
      else             reg_write(A_TX, 32'h0000_00EE);
    end
    reg_write(A_TXM, 32'd1);
    for (int i = 0; i < DEPTH; i++) tx_take(WIDTH'(8'hA0 + i));
    @(negedge clk); #1;
    check("R3 dropped write", 32'(tx_valid), 32'd0);

    // R7 / R4 sweep
    for (int occ = 0; occ <= DEPTH; occ++) begin
      for (int m = 0; m <= DEPTH; m++) begin
        reg_write(A_RXM, 32'(m));
        reg_read(A_PEND, d);
        check("R7 rx pend", 32'(d[1]), 32'(occ > m));
      end
      @(negedge clk); #1;
      check("R4 rx_ready", 32'(rx_ready), 32'(occ < DEPTH));
      rx_push((occ < DEPTH) ? WIDTH'(8'h30 + occ) : WIDTH'(8'h77));
    end
    reg_write(A_RXM, 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      reg_read(A_RX, d);
      check("R5 rx read", d, 32'(8'h30 + i));
    end
    reg_read(A_RX, d); check("R5 empty read", d, 32'h8000_0000);
    reg_read(A_RX, d); check("R5 empty again", d, 32'h8000_0000);
    rx_push(8'h55);
    reg_read(A_RX, d); check("R5 after empty", d, 32'h55);

    // R8 interrupt masking: rx holds one byte
    rx_push(8'h11);
    for (int tm = 0; tm < 2; tm++) begin
      for (int rsel = 0; rsel < 2; rsel++) begin
        reg_write(A_TXM, 32'(tm));
        reg_write(A_RXM, (rsel == 0) ? 32'd0 : 32'(DEPTH));
        for (int en = 0; en < 4; en++) begin
          logic [1:0] p;
          p = {1'(rsel == 0), 1'(tm == 1)};
          reg_write(A_EN, 32'(en));
          check("R8 irq", 32'(irq), 32'(|(p & 2'(en))));
        end
      end
    end
    reg_write(A_EN, 32'd0);
    reg_write(A_TXM, 32'd1);
    reg_write(A_RXM, 32'd0);

    // R9 pending is read-only (tx empty below mark 1, rx holds one above 0)
    reg_write(A_PEND, 32'd0);
    reg_read(A_PEND, d); check("R9 pend ro", d, 32'd3);
    reg_read(A_RX, d);   check("R5 drain", d, 32'h11);
    reg_write(A_PEND, 32'd3);
    reg_read(A_PEND, d); check("R9 pend ro2", d, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule